// File: doc/BRIEF.md
# Single-Cycle Decoded Register Machine

This block is a small programmable core in which every 16-bit instruction finishes in one clock as one datapath operation. A decoder turns the instruction into a control word: destination, two source register addresses, a constant-or-register select for the second operand, a function code, a write-back source, a register-write enable, a memory-write enable and a branch flag. The control word drives an eight-entry register file, a function unit, a small data memory and a program counter.

The instruction comes in on `instr_i` and must match the address on `pc_o` in the same cycle, as if fetched from a combinational instruction store. The data memory sits inside the block. Its write side is visible on the `mem_*_o` outputs. The only path from register contents to the pins is a store instruction, so that is how the state of the registers can be seen.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0. An all-zero instruction (opcode 0, which is undefined) keeps `mem_we_o` at 0.
- R2: The instruction word is split into fields as follows: opcode = bits 15:9, rd = bits 8:6, ra = bits 5:3, rb = bits 2:0. Every instruction other than a taken branch advances `pc_o` by one, modulo 2^PC_W, at the next rising edge.
- R3: The register opcodes write the following results into rd, wrapping to 16 bits:
  - 0x01 MOV: rd = ra
  - 0x02 ADD: rd = ra + rb
  - 0x05 SUB: rd = ra - rb
  - 0x08 AND: rd = ra & rb
  - 0x09 OR: rd = ra | rb
  - 0x0A XOR: rd = ra ^ rb
  - 0x0E SHL: rd = ra << 1
  - 0x0D SHR: rd = ra >> 1 (logical)
- R4: Two opcodes use the immediate format, in which bits 2:0 are zero-extended to a 16-bit constant that replaces rb. These are 0x42 ADI (rd = ra + constant) and 0x4C LDI (rd = constant).
- R5: Opcode 0x20 ST asserts `mem_we_o` for its cycle, with `mem_addr_o` = the low address bits of R[ra] and `mem_wdata_o` = R[rb]. The memory word is written at the rising edge. No other opcode asserts `mem_we_o`.
- R6: Opcode 0x10 LD writes rd with the data-memory word at the low address bits of R[ra], including a word stored by an earlier ST.
- R7: Opcode 0x60 BEQ compares R[ra] with R[rb].
  - If they are equal, the next PC is PC + sign-extended {rd, rb}, a 6-bit offset.
  - Otherwise the next PC is PC + 1.
  - BEQ writes neither registers nor memory.
- R8: Register 0 is an ordinary register that can be written and read like the others.
- R9: An undefined opcode writes no register and no memory, and advances the PC by one.
- R10: A register written by one instruction is read with its new value by the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction at address `pc_o` |
| pc_o | output | PC_W | Current program counter |
| mem_we_o | output | 1 | Data-memory write enable (ST) |
| mem_addr_o | output | DM_AW | Data-memory address from R[ra] |
| mem_wdata_o | output | W | Data-memory write data from R[rb] |

## Verification
The `mem_*_o` outputs are combinational from the instruction and the current registers, so the bench checks them in the same cycle as the instruction. It drives each instruction on the falling edge and samples 1 ns later. A register result is due after one rising edge, so each result is checked through a store issued on the next falling edge. That store has ra = rb = the register under test. `pc_o` is due one edge after its instruction and is compared at the following falling edge, with the expected PC kept by the bench as +1 or + the signed branch offset.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OP_W    = 7;
  localparam int unsigned RSEL_W  = 3;
  localparam int unsigned RF_N    = 1 << RSEL_W;
  localparam int unsigned OFF_W   = 2 * RSEL_W;

  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OP_MOV = 7'h01;
  localparam opcode_t OP_ADD = 7'h02;
  localparam opcode_t OP_SUB = 7'h05;
  localparam opcode_t OP_AND = 7'h08;
  localparam opcode_t OP_OR  = 7'h09;
  localparam opcode_t OP_XOR = 7'h0A;
  localparam opcode_t OP_SHR = 7'h0D;
  localparam opcode_t OP_SHL = 7'h0E;
  localparam opcode_t OP_LD  = 7'h10;
  localparam opcode_t OP_ST  = 7'h20;
  localparam opcode_t OP_ADI = 7'h42;
  localparam opcode_t OP_LDI = 7'h4C;
  localparam opcode_t OP_BEQ = 7'h60;

  typedef enum logic [3:0] {
    FN_PASS_A, FN_PASS_B, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SHL, FN_SHR
  } fn_e;

  typedef enum logic {WB_FN, WB_MEM} wb_e;

  typedef struct packed {
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src_a;
    logic [RSEL_W-1:0] src_b;
    logic              use_const;
    fn_e               fn;
    wb_e               wb_sel;
    logic              reg_we;
    logic              mem_we;
    logic              branch;
    logic [OFF_W-1:0]  br_off;
  } ctrl_t;

  function automatic logic op_defined(opcode_t op);
    case (op)
      OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHR, OP_SHL,
      OP_LD, OP_ST, OP_ADI, OP_LDI, OP_BEQ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              cw_o
);
  opcode_t op;
  assign op = instr_i[INSTR_W-1 -: OP_W];

  always_comb begin
    cw_o        = '0;
    cw_o.dst    = instr_i[3*RSEL_W-1 -: RSEL_W];
    cw_o.src_a  = instr_i[2*RSEL_W-1 -: RSEL_W];
    cw_o.src_b  = instr_i[RSEL_W-1:0];
    cw_o.br_off = {instr_i[3*RSEL_W-1 -: RSEL_W], instr_i[RSEL_W-1:0]};
    cw_o.fn     = FN_PASS_A;
    cw_o.wb_sel = WB_FN;
    case (op)
      OP_MOV: begin cw_o.fn = FN_PASS_A; cw_o.reg_we = 1'b1; end
      OP_ADD: begin cw_o.fn = FN_ADD;    cw_o.reg_we = 1'b1; end
      OP_SUB: begin cw_o.fn = FN_SUB;    cw_o.reg_we = 1'b1; end
      OP_AND: begin cw_o.fn = FN_AND;    cw_o.reg_we = 1'b1; end
      OP_OR:  begin cw_o.fn = FN_OR;     cw_o.reg_we = 1'b1; end
      OP_XOR: begin cw_o.fn = FN_XOR;    cw_o.reg_we = 1'b1; end
      OP_SHL: begin cw_o.fn = FN_SHL;    cw_o.reg_we = 1'b1; end
      OP_SHR: begin cw_o.fn = FN_SHR;    cw_o.reg_we = 1'b1; end
      OP_LD:  begin cw_o.wb_sel = WB_MEM; cw_o.reg_we = 1'b1; end
      OP_ST:  cw_o.mem_we = 1'b1;
      OP_ADI: begin cw_o.use_const = 1'b1; cw_o.fn = FN_ADD;    cw_o.reg_we = 1'b1; end
      OP_LDI: begin cw_o.use_const = 1'b1; cw_o.fn = FN_PASS_B; cw_o.reg_we = 1'b1; end
      OP_BEQ: cw_o.branch = 1'b1;
      default: ;  // undefined: no-op
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 8,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))          regs_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  fn_e          fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (fn_i)
      FN_PASS_A: y_o = a_i;
      FN_PASS_B: y_o = b_i;
      FN_ADD:    y_o = a_i + b_i;
      FN_SUB:    y_o = a_i - b_i;
      FN_AND:    y_o = a_i & b_i;
      FN_OR:     y_o = a_i | b_i;
      FN_XOR:    y_o = a_i ^ b_i;
      FN_SHL:    y_o = a_i << 1;
      FN_SHR:    y_o = a_i >> 1;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned PC_W     = 8,
  parameter int unsigned DM_DEPTH = 16,
  localparam int unsigned DM_AW   = $clog2(DM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               mem_we_o,
  output logic [DM_AW-1:0]   mem_addr_o,
  output logic [W-1:0]       mem_wdata_o
);
  ctrl_t            cw;
  logic [W-1:0]     rdata_a, rdata_b, opnd_b, fn_y, wb_data;
  logic             reg_we, src_eq;
  logic [PC_W-1:0]  pc_q, br_sext;
  logic [W-1:0]     dmem [DM_DEPTH];

  sc_decode u_dec (.instr_i(instr_i), .cw_o(cw));

  sc_regfile #(.W(W), .N(RF_N)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .waddr_i  (cw.dst),
    .wdata_i  (wb_data),
    .raddr_a_i(cw.src_a),
    .raddr_b_i(cw.src_b),
    .rdata_a_o(rdata_a),
    .rdata_b_o(rdata_b)
  );

  // immediate format: zero-extended 3-bit constant in place of rb
  assign opnd_b = cw.use_const ? {{(W-RSEL_W){1'b0}}, cw.src_b} : rdata_b;

  sc_alu #(.W(W)) u_alu (.fn_i(cw.fn), .a_i(rdata_a), .b_i(opnd_b), .y_o(fn_y));

  assign mem_we_o    = cw.mem_we;
  assign mem_addr_o  = rdata_a[DM_AW-1:0];
  assign mem_wdata_o = rdata_b;

  always_ff @(posedge clk_i) begin
    if (cw.mem_we) dmem[mem_addr_o] <= rdata_b;
  end

  assign wb_data = (cw.wb_sel == WB_MEM) ? dmem[mem_addr_o] : fn_y;
  assign reg_we  = cw.reg_we;
  assign src_eq  = (rdata_a == rdata_b);
  assign br_sext = {{(PC_W-OFF_W){cw.br_off[OFF_W-1]}}, cw.br_off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pc_q <= '0;
    else if (cw.branch && src_eq) pc_q <= pc_q + br_sext;
    else                          pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int unsigned PC_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic [PC_W-1:0]    pc_o,
  input logic               mem_we_o,
  input logic               reg_we_i,
  input logic               src_eq_i
);
  opcode_t op;
  assign op = instr_i[INSTR_W-1 -: OP_W];

  a_r1_reset_pc: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op != OP_BEQ |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r7_beq_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && !src_eq_i) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r5_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> op == OP_ST);

  a_r9_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_defined(op) |-> (!mem_we_o && !reg_we_i));
endmodule

bind sc_core sc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .instr_i (instr_i),
  .pc_o    (pc_o),
  .mem_we_o(mem_we_o),
  .reg_we_i(reg_we),
  .src_eq_i(src_eq)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  import sc_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic [7:0]  pc_o;
  logic        mem_we_o;
  logic [3:0]  mem_addr_o;
  logic [15:0] mem_wdata_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_pc;

  always #2 clk_i = ~clk_i;

  sc_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .pc_o(pc_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  function automatic logic [15:0] enc(opcode_t op, int rd, int ra, int rb);
    return {op, 3'(rd), 3'(ra), 3'(rb)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns later; checks pc of this instruction
  task automatic issue(logic [15:0] ins, logic [7:0] delta, string pc_tag);
    @(negedge clk_i);
    instr_i = ins;
    #1;
    chk(pc_tag, 32'(pc_o), 32'(exp_pc));
    exp_pc = exp_pc + delta;
  endtask

  // expose a register through a store with ra = rb = r
  task automatic peek(int r, logic [15:0] exp, string tag);
    issue(enc(OP_ST, 0, r, r), 8'd1, "R2 pc");
    chk(tag, 32'(mem_we_o), 32'd1);
    chk(tag, 32'(mem_wdata_o), 32'(exp));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 pc in reset", 32'(pc_o), 32'd0);
    chk("R1 no write on zero instr", 32'(mem_we_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_pc = 8'd1;  // next edge executes the all-zero no-op
  endtask

  task automatic t_imm;
    issue(enc(OP_LDI, 1, 6, 5), 8'd1, "R2 pc");
    peek(1, 16'd5, "R4 LDI");
    issue(enc(OP_ADI, 3, 1, 7), 8'd1, "R2 pc");
    peek(3, 16'd12, "R4 ADI zero-extended");
    issue(enc(OP_LDI, 2, 0, 3), 8'd1, "R2 pc");
  endtask

  task automatic t_alu;
    issue(enc(OP_ADD, 4, 1, 2), 8'd1, "R2 pc"); peek(4, 16'd8, "R3 ADD");
    issue(enc(OP_SUB, 5, 2, 1), 8'd1, "R2 pc"); peek(5, 16'hFFFE, "R3 SUB wrap");
    issue(enc(OP_AND, 6, 1, 2), 8'd1, "R2 pc"); peek(6, 16'd1, "R3 AND");
    issue(enc(OP_OR, 6, 1, 2), 8'd1, "R2 pc");  peek(6, 16'd7, "R3 OR");
    issue(enc(OP_XOR, 6, 1, 2), 8'd1, "R2 pc"); peek(6, 16'd6, "R3 XOR");
    issue(enc(OP_SHL, 6, 1, 0), 8'd1, "R2 pc"); peek(6, 16'd10, "R3 SHL");
    issue(enc(OP_SHR, 6, 1, 0), 8'd1, "R2 pc"); peek(6, 16'd2, "R3 SHR");
    issue(enc(OP_MOV, 7, 3, 0), 8'd1, "R2 pc"); peek(7, 16'd12, "R3 MOV");
    issue(enc(OP_ADD, 4, 1, 2), 8'd1, "R2 pc");
    chk("R5 no store on ADD", 32'(mem_we_o), 32'd0);
    issue(enc(OP_ADD, 4, 4, 4), 8'd1, "R2 pc");
    peek(4, 16'd16, "R10 back-to-back");
  endtask

  task automatic t_store_load;
    issue(enc(OP_LDI, 6, 0, 6), 8'd1, "R2 pc");
    issue(enc(OP_ST, 0, 6, 3), 8'd1, "R2 pc");
    chk("R5 store we", 32'(mem_we_o), 32'd1);
    chk("R5 store addr", 32'(mem_addr_o), 32'd6);
    chk("R5 store data", 32'(mem_wdata_o), 32'd12);
    issue(enc(OP_LDI, 2, 0, 2), 8'd1, "R2 pc");
    issue(enc(OP_ST, 0, 2, 1), 8'd1, "R2 pc");
    issue(enc(OP_LD, 4, 6, 0), 8'd1, "R2 pc");
    peek(4, 16'd12, "R6 load addr 6");
    issue(enc(OP_LD, 5, 2, 0), 8'd1, "R2 pc");
    peek(5, 16'd5, "R6 load addr 2");
  endtask

  task automatic t_r0;
    issue(enc(OP_LDI, 0, 0, 7), 8'd1, "R2 pc");
    issue(enc(OP_ADD, 0, 0, 0), 8'd1, "R2 pc");
    peek(0, 16'd14, "R8 register 0 writable");
  endtask

  task automatic t_undef;
    issue(enc(OP_LDI, 1, 0, 5), 8'd1, "R2 pc");
    issue(enc(7'h7F, 1, 1, 1), 8'd1, "R2 pc");
    chk("R9 no mem write 7F", 32'(mem_we_o), 32'd0);
    issue(enc(7'h03, 1, 0, 0), 8'd1, "R9 pc advance");
    chk("R9 no mem write 03", 32'(mem_we_o), 32'd0);
    issue(enc(7'h21, 1, 1, 1), 8'd1, "R9 pc advance");
    chk("R9 no mem write 21", 32'(mem_we_o), 32'd0);
    peek(1, 16'd5, "R9 register kept");
  endtask

  task automatic t_branch;
    issue(enc(OP_LDI, 7, 0, 4), 8'd1, "R2 pc");
    issue(enc(OP_LDI, 5, 0, 3), 8'd1, "R2 pc");
    issue(enc(OP_LDI, 2, 0, 3), 8'd1, "R2 pc");
    issue(enc(OP_BEQ, 0, 2, 5), 8'd5, "R2 pc");
    chk("R7 BEQ no mem write", 32'(mem_we_o), 32'd0);
    issue(enc(OP_LDI, 6, 0, 1), 8'd1, "R7 taken forward +5");
    issue(enc(OP_BEQ, 7, 2, 6), 8'd1, "R2 pc");
    issue(enc(OP_LDI, 6, 0, 3), 8'd1, "R7 not taken +1");
    issue(enc(OP_BEQ, 7, 2, 6), 8'hFE, "R2 pc");
    issue(16'h0000, 8'd1, "R7 taken backward -2");
    peek(7, 16'd4, "R7 BEQ no register write");
  endtask

  initial begin
    exp_pc = '0;
    t_reset;
    t_imm;
    t_alu;
    t_store_load;
    t_r0;
    t_undef;
    t_branch;
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule